// File: doc/BRIEF.md
# Palette Colour Write Port

This block lets a processor fill a 256-entry colour table one byte at a time. Each entry holds a 15-bit colour made of three 5-bit channels. The processor first loads an 8-bit entry pointer. It then writes bytes to a single data port. A byte-phase flag sends each byte to either the low half or the high half of the entry that the pointer addresses. After every high half, the pointer steps to the next entry, so a stream of byte pairs fills consecutive colours.

Only 15 of the 16 bits in a byte pair are stored. The top bit of the high byte is discarded. The green channel straddles the two bytes, so a colour is complete only after both halves have been written.

When a data write really changes the stored value, the block emits a one-cycle change pulse. The pulse carries the entry number, the full new colour and that colour split into its red, green and blue channels. A downstream brightness or colour-conversion stage can keep a shadow copy from this pulse. A write that leaves the entry as it was produces no pulse.

Top module: `pal_write_port`

## Requirements
- R1: After synchronous reset the pointer is 0, the byte phase is low and no change pulse is emitted. Every table entry holds 0 from start-up; reset does not clear the table.
- R2: A data write in the low phase puts the 8 data bits into entry bits 7:0 of the addressed entry and leaves the pointer unchanged.
- R3: A data write in the high phase puts data bits 6:0 into entry bits 14:8 and ignores data bit 7. The pointer then advances by one.
- R4: Each accepted data write flips the byte phase, so writes alternate low, high, low, and so on.
- R5: In the change pulse, red is colour bits 4:0, green is colour bits 9:5 and blue is colour bits 14:10.
- R6: The pointer is 8 bits wide and wraps from 255 to 0 after a high-phase write.
- R7: A pointer write loads the pointer from the 8-bit input and forces the byte phase to low.
- R8: The change pulse lasts one cycle and carries the entry number and the new 15-bit colour. It is high in the second cycle after the write is presented, and only when the stored value differs from its previous value.
- R9: If a pointer write and a data write arrive in the same cycle, the pointer write takes effect and the data byte is dropped. No entry changes and no pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Load the entry pointer this cycle |
| idx_in | input | 8 | New entry pointer value |
| byte_wr | input | 1 | Present a colour data byte this cycle |
| byte_in | input | 8 | Colour data byte |
| chg_valid | output | 1 | One-cycle pulse: an entry has changed |
| chg_index | output | 8 | Entry that changed |
| chg_color | output | 15 | New colour of that entry |
| chg_red | output | 5 | Red channel of the new colour |
| chg_green | output | 5 | Green channel of the new colour |
| chg_blue | output | 5 | Blue channel of the new colour |

## Verification
A wrong pointer or a wrong byte phase shows on the next pulse as the wrong entry number, or as a byte landing in the wrong half. A fault that goes unnoticed in one write therefore appears at the ports within one or two data writes. A stale value read back from the table, for example when the two halves of one entry are written back to back, shows as a pulse that carries the other half's old bits, or as a pulse that is missing or extra. Such a fault is visible two cycles after the faulty write. The reference model keeps its own copy of the table and compares every cycle, so an internal error surfaces at the first later write that depends on it.

// File: rtl/palw_pkg.sv
package palw_pkg;
  parameter int unsigned PTR_W  = 8;
  parameter int unsigned CHAN_W = 5;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/palw_seq.sv
module palw_seq
  import palw_pkg::*;
#(
  parameter int unsigned PTR_W = palw_pkg::PTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr,
  input  logic [PTR_W-1:0] idx_in,
  input  logic             byte_wr,
  output logic             req_valid,
  output logic [PTR_W-1:0] req_ptr,
  output logic             req_high
);
  logic [PTR_W-1:0] ptr_q;
  half_e            half_q;

  assign req_valid = byte_wr && !idx_wr;
  assign req_ptr   = ptr_q;
  assign req_high  = (half_q == HALF_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      half_q <= HALF_LO;
    end else if (idx_wr) begin
      ptr_q  <= idx_in;
      half_q <= HALF_LO;
    end else if (byte_wr) begin
      half_q <= (half_q == HALF_HI) ? HALF_LO : HALF_HI;
      if (half_q == HALF_HI) ptr_q <= ptr_q + 1'b1;
    end
  end

  // R4: every accepted data byte flips the phase
  assert_phase_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && !idx_wr) |=> (half_q != $past(half_q)));

  // R2: low-phase byte keeps the pointer
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && !idx_wr && half_q == HALF_LO) |=> (ptr_q == $past(ptr_q)));

  // R3 / R6: high-phase byte advances the pointer modulo its width
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && !idx_wr && half_q == HALF_HI) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  // R7 / R9: pointer load wins and clears the phase
  assert_ptr_load_R7: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (ptr_q == $past(idx_in) && half_q == HALF_LO));
endmodule

// File: rtl/palw_store.sv
module palw_store #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned COL_W  = 15,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic              req_high,
  input  logic [BYTE_W-1:0] req_data,
  output logic              chg_valid,
  output logic [PTR_W-1:0]  chg_index,
  output logic [COL_W-1:0]  chg_color
);
  localparam int unsigned DEPTH = 1 << PTR_W;
  localparam int unsigned HI_W  = COL_W - BYTE_W;

  logic [COL_W-1:0] table_q [DEPTH];

  logic              a_valid;
  logic [PTR_W-1:0]  a_ptr;
  logic              a_high;
  logic [BYTE_W-1:0] a_data;
  logic              a_fwd;
  logic [COL_W-1:0]  rd_q;
  logic [COL_W-1:0]  last_q;

  logic [COL_W-1:0]  old_val;
  logic [COL_W-1:0]  new_val;
  logic              wr_en;

  initial begin
    for (int i = 0; i < DEPTH; i++) table_q[i] = '0;
  end

  // stage A: capture request and read the addressed entry
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_fwd   <= 1'b0;
    end else begin
      a_valid <= req_valid;
      a_fwd   <= wr_en && (a_ptr == req_ptr);
    end
    a_ptr  <= req_ptr;
    a_high <= req_high;
    a_data <= req_data;
  end

  // stage B: merge byte, compare, write back
  always_comb begin
    old_val = a_fwd ? last_q : rd_q;
    if (a_high) new_val = {a_data[HI_W-1:0], old_val[BYTE_W-1:0]};
    else        new_val = {old_val[COL_W-1:BYTE_W], a_data};
    wr_en = a_valid && !rst && (new_val != old_val);
  end

  always_ff @(posedge clk) begin
    if (wr_en) table_q[a_ptr] <= new_val;
    rd_q <= table_q[req_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) chg_valid <= 1'b0;
    else     chg_valid <= wr_en;
    last_q    <= new_val;
    chg_index <= a_ptr;
    chg_color <= new_val;
  end

  // R8: a pulse needs a request in the cycle before
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> $past(a_valid));

  // R3: the high half carries the 7 low data bits
  assert_high_half_R3: assert property (@(posedge clk) disable iff (rst)
    (chg_valid && $past(a_high)) |-> (chg_color[COL_W-1:BYTE_W] == $past(a_data[HI_W-1:0])));

  // R2: the low half carries the full data byte
  assert_low_half_R2: assert property (@(posedge clk) disable iff (rst)
    (chg_valid && !$past(a_high)) |-> (chg_color[BYTE_W-1:0] == $past(a_data)));
endmodule

// File: rtl/pal_write_port.sv
module pal_write_port
  import palw_pkg::*;
#(
  parameter int unsigned PTR_W  = palw_pkg::PTR_W,
  parameter int unsigned CHAN_W = palw_pkg::CHAN_W,
  parameter int unsigned BYTE_W = palw_pkg::BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idx_wr,
  input  logic [PTR_W-1:0]    idx_in,
  input  logic                byte_wr,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic                chg_valid,
  output logic [PTR_W-1:0]    chg_index,
  output logic [3*CHAN_W-1:0] chg_color,
  output logic [CHAN_W-1:0]   chg_red,
  output logic [CHAN_W-1:0]   chg_green,
  output logic [CHAN_W-1:0]   chg_blue
);
  localparam int unsigned COL_W = 3 * CHAN_W;

  logic             req_valid;
  logic [PTR_W-1:0] req_ptr;
  logic             req_high;
  logic [CHAN_W-1:0] chan [3];

  palw_seq #(.PTR_W(PTR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .idx_in   (idx_in),
    .byte_wr  (byte_wr),
    .req_valid(req_valid),
    .req_ptr  (req_ptr),
    .req_high (req_high)
  );

  palw_store #(.PTR_W(PTR_W), .COL_W(COL_W), .BYTE_W(BYTE_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ptr  (req_ptr),
    .req_high (req_high),
    .req_data (byte_in),
    .chg_valid(chg_valid),
    .chg_index(chg_index),
    .chg_color(chg_color)
  );

  // channel split: 0 = red (low bits), 1 = green, 2 = blue (high bits)
  for (genvar g = 0; g < 3; g++) begin : g_chan
    assign chan[g] = chg_color[g*CHAN_W +: CHAN_W];
  end

  assign chg_red   = chan[0];
  assign chg_green = chan[1];
  assign chg_blue  = chan[2];

  // R5: channels follow the registered colour while a pulse is shown
  assert_blue_top_R5: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> (chg_blue == $past(u_store.new_val[COL_W-1 -: CHAN_W])));
endmodule

// File: tb/pal_write_port_bench.sv
module pal_write_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idx_wr = 1'b0;
  logic [7:0] idx_in = '0;
  logic       byte_wr = 1'b0;
  logic [7:0] byte_in = '0;
  logic        chg_valid;
  logic [7:0]  chg_index;
  logic [14:0] chg_color;
  logic [4:0]  chg_red, chg_green, chg_blue;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pal_write_port u_pal_write_port (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .idx_in(idx_in),
    .byte_wr(byte_wr), .byte_in(byte_in), .chg_valid(chg_valid),
    .chg_index(chg_index), .chg_color(chg_color), .chg_red(chg_red),
    .chg_green(chg_green), .chg_blue(chg_blue)
  );

  // behavioural reference model
  int m_tab [256];
  int m_ptr = 0;
  bit m_hi = 1'b0;
  bit pend_v = 1'b0, exp_v = 1'b0;
  int pend_i = 0, exp_i = 0, pend_c = 0, exp_c = 0;

  initial for (int i = 0; i < 256; i++) m_tab[i] = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_hi = 1'b0; pend_v = 1'b0; exp_v = 1'b0;
    end else begin
      bit nv;
      int ni, nc;
      exp_v = pend_v; exp_i = pend_i; exp_c = pend_c;
      nv = 1'b0; ni = 0; nc = 0;
      if (idx_wr) begin
        m_ptr = idx_in; m_hi = 1'b0;
      end else if (byte_wr) begin
        int oldc, newc;
        oldc = m_tab[m_ptr];
        if (m_hi) newc = ((byte_in % 128) * 256) + (oldc % 256);
        else      newc = (oldc / 256) * 256 + byte_in;
        if (newc != oldc) begin
          m_tab[m_ptr] = newc; nv = 1'b1; ni = m_ptr; nc = newc;
        end
        if (m_hi) m_ptr = (m_ptr + 1) % 256;
        m_hi = !m_hi;
      end
      pend_v = nv; pend_i = ni; pend_c = nc;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk(chg_valid == exp_v, "pulse", chg_valid, exp_v);
      if (exp_v && chg_valid) begin
        chk(chg_index == exp_i[7:0], "index", chg_index, exp_i);
        chk(chg_color == exp_c[14:0], "colour", chg_color, exp_c);
        chk(chg_red == exp_c[4:0], "red R5", chg_red, exp_c % 32);
        chk(chg_green == exp_c[9:5], "green R5", chg_green, (exp_c / 32) % 32);
        chk(chg_blue == exp_c[14:10], "blue R5", chg_blue, exp_c / 1024);
      end
    end
  end

  task automatic cyc(bit iw, logic [7:0] iv, bit bw, logic [7:0] bv);
    @(negedge clk);
    idx_wr = iw; idx_in = iv; byte_wr = bw; byte_in = bv;
  endtask
  task automatic wr(logic [7:0] b);  cyc(1'b0, 8'h00, 1'b1, b); endtask
  task automatic ptr(logic [7:0] p); cyc(1'b1, p, 1'b0, 8'h00); endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_en = 1'b1;            // R1: no pulse while in reset
    @(negedge clk);
    rst = 1'b0;
    tag = "R1"; wr(8'h1F); idle(3);                   // entry 0 low, ptr 0
    tag = "R3"; wr(8'hFF); idle(3);                   // bit 7 dropped, ptr -> 1
    tag = "R2"; wr(8'hAA); idle(3);                   // entry 1 low
    tag = "R4"; wr(8'h55); wr(8'h11); wr(8'h22); idle(3);
    tag = "R8"; ptr(8'd0); wr(8'h1F); wr(8'hFF); idle(3); // unchanged, no pulse
    tag = "R8"; ptr(8'd7); wr(8'h01); wr(8'h02); wr(8'h03); idle(3); // back-to-back
    tag = "R7"; ptr(8'd5); wr(8'h01); ptr(8'd5); wr(8'h02); idle(3);
    tag = "R6"; ptr(8'd255); wr(8'h10); wr(8'h20); wr(8'h30); idle(3);
    tag = "R9"; cyc(1'b1, 8'd9, 1'b1, 8'h44); idle(3); wr(8'h66); idle(3);
    tag = "R1"; ptr(8'd40); wr(8'h00); wr(8'h00); idle(3); // table starts at zero
    tag = "R5"; ptr(8'd3); wr(8'hE0); wr(8'h03); idle(1);
    @(negedge clk);
    chk(chg_valid == 1'b1, "R5 pulse", chg_valid, 1);
    chk(chg_green == 5'h1F, "R5 green straddle", chg_green, 5'h1F);
    chk(chg_red == 5'h00, "R5 red", chg_red, 0);
    chk(chg_blue == 5'h00, "R5 blue", chg_blue, 0);
    idle(3);
    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      bit iw, bw;
      logic [7:0] d;
      iw = ($urandom % 20) == 0;
      bw = ($urandom % 5) < 3;
      d  = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      cyc(iw, 8'($urandom % 8), bw, d);
    end
    idle(4);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule